// File: doc/BRIEF.md
# Block Vote Merge Unit

This unit sits inside a line-detection voting engine. It takes one block of eight binary feature pixels, laid out as two rows of four columns, together with the fractional bits of the distance value belonging to the block's reference pixel. For the current angle it works out, for every pixel, a small integer offset. That offset says how far above the reference integer distance the pixel's own distance falls. The offset comes from adding the fraction to a per-pixel fixed-point constant and keeping the bits just above the binary point.

Pixels that share an offset are merged, so the block produces five vote counts, one for each offset from 0 to 4. A single read-modify-write of five neighbouring accumulator words can then absorb the whole block.

A host writes the eight per-pixel constants before a run. One constant set can serve both angles of a pair that are processed together. Blocks can be presented on every clock. Results appear a fixed two cycles later with a valid flag.

Top module: `vote_merge_unit`

## Requirements
- R1: After reset, out_valid is 0, all five counts are 0 and all eight constants are 0, so a block presented before any write votes with offset 0 for every pixel.
- R2: The offset of pixel i is bits [F+2:F] of the sum of zero-extended in_frac and constant i, with the sum taken modulo 2^(F+3) (F = FRAC_W, default 12).
- R3: Count k, at out_cnt bits [4k+3:4k] for k = 0..4, equals the number of pixels i whose bit in_pix[i] is 1 and whose offset is k. Pixel i sits at row i/4, column i%4, and pairs with constant index i.
- R4: Pixels whose feature bit is 0 add nothing. An all-zero block yields out_valid 1 with five zero counts.
- R5: A feature pixel whose offset is 5, 6 or 7 adds to no count.
- R6: A block accepted with in_valid high at a rising edge gives out_valid high after the second rising edge that follows. Blocks may arrive on back-to-back cycles.
- R7: While out_valid is 0 all counts read 0, whatever in_pix and in_frac carried in the cycle that was not valid.
- R8: cfg_we high at a rising edge stores cfg_val into constant cfg_idx. A block accepted at that same edge still uses the old constant, and blocks accepted later use the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Constant write strobe |
| cfg_idx | input | 3 | Pixel index of the constant being written |
| cfg_val | input | 15 | Unsigned constant, 3 integer and FRAC_W fraction bits |
| in_valid | input | 1 | Block present on in_pix / in_frac |
| in_pix | input | 8 | Feature bits, bit i = pixel i |
| in_frac | input | 12 | Fraction bits of the reference distance |
| out_valid | output | 1 | Counts valid |
| out_cnt | output | 20 | Five 4-bit counts, offset k at bits [4k+3:4k] |

## Verification
The assertions assume that the host keeps the constants inside the range the angle allows, and that in_valid and cfg_we are driven as clean levels from reset onwards. The count-total property is a bound, not an equality, because offsets above 4 are dropped legally. The stimulus writes constants while blocks stream through, including a write in the same cycle as a block. It loads values that push offsets past 4 and values that wrap the sum, and it toggles in_valid while it keeps driving noise on the data inputs.

// File: rtl/vm_pkg.sv
package vm_pkg;
    localparam int VM_OFS_W  = 3;
    localparam int VM_NUM_OFS = 5;
    localparam int VM_OFS_LINES = 1 << VM_OFS_W;
endpackage

// File: rtl/vm_const_regs.sv
module vm_const_regs #(
    parameter int NPIX = 8,
    parameter int CW   = 15,
    localparam int IDX_W = $clog2(NPIX)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [IDX_W-1:0]          cfg_idx,
    input  logic [CW-1:0]             cfg_val,
    output logic [NPIX-1:0][CW-1:0]   consts
);
    typedef struct packed {
        logic [NPIX-1:0][CW-1:0] tab;
    } reg_t;

    reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (cfg_we) begin
            r_d.tab[cfg_idx] = cfg_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign consts = r_q.tab;

    // R8: without a write strobe the table holds
    a_r8_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(r_q.tab));
endmodule

// File: rtl/vm_offset_stage.sv
module vm_offset_stage
    import vm_pkg::*;
#(
    parameter int NPIX   = 8,
    parameter int FRAC_W = 12,
    localparam int CW    = FRAC_W + VM_OFS_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_valid,
    input  logic [NPIX-1:0]                in_pix,
    input  logic [FRAC_W-1:0]              in_frac,
    input  logic [NPIX-1:0][CW-1:0]        consts,
    output logic                           s1_valid,
    output logic [NPIX-1:0]                s1_pix,
    output logic [NPIX-1:0][VM_OFS_W-1:0]  s1_ofs
);
    typedef struct packed {
        logic                          vld;
        logic [NPIX-1:0]               pix;
        logic [NPIX-1:0][VM_OFS_W-1:0] ofs;
    } st_t;

    st_t s_d, s_q;
    logic [NPIX-1:0][CW-1:0] sum;

    for (genvar i = 0; i < NPIX; i++) begin : g_add
        assign sum[i] = {{VM_OFS_W{1'b0}}, in_frac} + consts[i];
    end

    always_comb begin
        s_d.vld = in_valid;
        s_d.pix = in_valid ? in_pix : '0;
        for (int i = 0; i < NPIX; i++) begin
            s_d.ofs[i] = in_valid ? sum[i][CW-1:FRAC_W] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign s1_valid = s_q.vld;
    assign s1_pix   = s_q.pix;
    assign s1_ofs   = s_q.ofs;

    // R7: an empty stage carries no feature bits forward
    a_r7_idle_stage_clean: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (s1_pix == '0));
endmodule

// File: rtl/vm_count_stage.sv
module vm_count_stage
    import vm_pkg::*;
#(
    parameter int NPIX  = 8,
    localparam int CNT_W = $clog2(NPIX + 1)
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                s1_valid,
    input  logic [NPIX-1:0]                     s1_pix,
    input  logic [NPIX-1:0][VM_OFS_W-1:0]       s1_ofs,
    output logic                                out_valid,
    output logic [VM_NUM_OFS-1:0][CNT_W-1:0]    out_cnt
);
    typedef struct packed {
        logic                             vld;
        logic [VM_NUM_OFS-1:0][CNT_W-1:0] cnt;
    } st_t;

    st_t s_d, s_q;
    logic [NPIX-1:0][VM_NUM_OFS-1:0] hit;

    for (genvar i = 0; i < NPIX; i++) begin : g_dec
        logic [VM_OFS_LINES-1:0] line;
        assign line   = VM_OFS_LINES'(1) << s1_ofs[i];
        assign hit[i] = line[VM_NUM_OFS-1:0] & {VM_NUM_OFS{s1_pix[i]}};
    end

    always_comb begin
        s_d.vld = s1_valid;
        s_d.cnt = '0;
        for (int k = 0; k < VM_NUM_OFS; k++) begin
            for (int i = 0; i < NPIX; i++) begin
                if (s1_valid && hit[i][k]) s_d.cnt[k] = s_d.cnt[k] + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_cnt   = s_q.cnt;

    // R6: output flag follows the stage-one flag by one edge
    a_r6_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> out_valid);
    a_r6_gap_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_valid |=> !out_valid);
    // R7: counts are zero whenever the flag is low
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_cnt == '0));

    for (genvar k = 0; k < VM_NUM_OFS; k++) begin : g_chk
        // R3: no count exceeds the pixel total
        a_r3_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
            out_cnt[k] <= CNT_W'(NPIX));
    end
endmodule

// File: rtl/vote_merge_unit.sv
module vote_merge_unit
    import vm_pkg::*;
#(
    parameter int FRAC_W = 12,
    parameter int ROWS   = 2,
    parameter int COLS   = 4,
    localparam int NPIX  = ROWS * COLS,
    localparam int IDX_W = $clog2(NPIX),
    localparam int CW    = FRAC_W + VM_OFS_W,
    localparam int CNT_W = $clog2(NPIX + 1),
    localparam int TOT_W = CNT_W + VM_OFS_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cfg_we,
    input  logic [IDX_W-1:0]              cfg_idx,
    input  logic [CW-1:0]                 cfg_val,
    input  logic                          in_valid,
    input  logic [NPIX-1:0]               in_pix,
    input  logic [FRAC_W-1:0]             in_frac,
    output logic                          out_valid,
    output logic [VM_NUM_OFS*CNT_W-1:0]   out_cnt
);
    logic [NPIX-1:0][CW-1:0]             consts;
    logic                                s1_valid;
    logic [NPIX-1:0]                     s1_pix;
    logic [NPIX-1:0][VM_OFS_W-1:0]       s1_ofs;
    logic [VM_NUM_OFS-1:0][CNT_W-1:0]    cnt;

    vm_const_regs #(.NPIX(NPIX), .CW(CW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_val(cfg_val), .consts(consts)
    );

    vm_offset_stage #(.NPIX(NPIX), .FRAC_W(FRAC_W)) u_ofs (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pix(in_pix),
        .in_frac(in_frac), .consts(consts), .s1_valid(s1_valid),
        .s1_pix(s1_pix), .s1_ofs(s1_ofs)
    );

    vm_count_stage #(.NPIX(NPIX)) u_cnt (
        .clk(clk), .rst_n(rst_n), .s1_valid(s1_valid), .s1_pix(s1_pix),
        .s1_ofs(s1_ofs), .out_valid(out_valid), .out_cnt(cnt)
    );

    assign out_cnt = cnt;

    logic [TOT_W-1:0] total;
    always_comb begin
        total = '0;
        for (int k = 0; k < VM_NUM_OFS; k++) total = total + TOT_W'(cnt[k]);
    end

    // R4, R5: merged votes never exceed the feature pixels of the block
    a_r4_total_bound: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 (int'(total) <= $countones($past(in_pix, 2))));
    // R4: an empty block yields no votes
    a_r4_empty_block: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_pix == '0) |=> ##1 (out_valid && total == '0));
    // R6: two-edge latency at the ports
    a_r6_port_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##1 out_valid);
endmodule

// File: tb/vote_merge_unit_bench.sv
module vote_merge_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [14:0] cfg_val = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_pix = '0;
    logic [11:0] in_frac = '0;
    logic        out_valid;
    logic [19:0] out_cnt;

    int checks = 0;
    int failures = 0;
    int mc [8];
    bit          q_v [$];
    logic [19:0] q_c [$];
    string       q_t [$];

    always #10 clk = ~clk;

    vote_merge_unit u_vote_merge_unit (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_val(cfg_val), .in_valid(in_valid), .in_pix(in_pix),
        .in_frac(in_frac), .out_valid(out_valid), .out_cnt(out_cnt)
    );

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    function automatic logic [19:0] model(input bit v, input logic [7:0] pix,
                                          input logic [11:0] frac);
        int cnt [5];
        logic [19:0] r;
        for (int k = 0; k < 5; k++) cnt[k] = 0;
        if (v) begin
            for (int i = 0; i < 8; i++) begin
                int o;
                o = ((int'(frac) + mc[i]) % 32768) / 4096;
                if (pix[i] && o <= 4) cnt[o]++;
            end
        end
        r = '0;
        for (int k = 0; k < 5; k++) r[4*k +: 4] = 4'(cnt[k]);
        return r;
    endfunction

    task automatic check_front();
        if (q_v.size() >= 2) begin
            bit ev;
            logic [19:0] ec;
            string t;
            ev = q_v.pop_front();
            ec = q_c.pop_front();
            t  = q_t.pop_front();
            checks++;
            if (out_valid !== ev || out_cnt !== ec) begin
                failures++;
                $display("FAIL %s valid=%0d cnt=%h expected valid=%0d cnt=%h",
                         t, out_valid, out_cnt, ev, ec);
            end
        end
    endtask

    task automatic drive(input bit v, input logic [7:0] pix, input logic [11:0] frac,
                         input bit we, input int idx, input int val, input string tag);
        check_front();
        in_valid = v; in_pix = pix; in_frac = frac;
        cfg_we = we; cfg_idx = 3'(idx); cfg_val = 15'(val);
        q_v.push_back(v);
        q_c.push_back(model(v, pix, frac));
        q_t.push_back(tag);
        if (we) mc[idx] = val;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        report();
    end

    initial begin
        for (int i = 0; i < 8; i++) mc[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state observed through two idle slots
        q_v.push_back(0); q_c.push_back('0); q_t.push_back("R1");
        q_v.push_back(0); q_c.push_back('0); q_t.push_back("R1");
        // R1: zero constants -> every pixel at offset 0
        drive(1, 8'hFF, 12'h000, 0, 0, 0, "R1");
        drive(1, 8'hA5, 12'hFFF, 0, 0, 0, "R1");
        // R8 + R7: load constants while idle with noise on data
        for (int i = 0; i < 8; i++)
            drive(0, 8'($urandom()), 12'($urandom()), 1, i, 1536 * i, "R7");
        // R3: several fractions, full block
        drive(1, 8'hFF, 12'h000, 0, 0, 0, "R3");
        drive(1, 8'hFF, 12'h800, 0, 0, 0, "R3");
        drive(1, 8'hFF, 12'hFFF, 0, 0, 0, "R3");
        drive(1, 8'h3C, 12'h400, 0, 0, 0, "R3");
        // R4: empty block
        drive(1, 8'h00, 12'h7FF, 0, 0, 0, "R4");
        // R8: same-cycle write uses old constant, next uses new
        drive(1, 8'h01, 12'h000, 1, 0, 16'h2000, "R8");
        drive(1, 8'h01, 12'h000, 0, 0, 0, "R8");
        // R5: offsets beyond 4 dropped
        drive(1, 8'h80, 12'h000, 1, 7, 16'h5000, "R5");
        drive(1, 8'h80, 12'h000, 0, 0, 0, "R5");
        drive(1, 8'hC0, 12'hFFF, 1, 6, 16'h4800, "R5");
        drive(1, 8'h40, 12'h000, 0, 0, 0, "R5");
        // R2: sum wraps modulo 2^15
        drive(1, 8'h40, 12'h900, 1, 6, 16'h7800, "R2");
        drive(1, 8'h40, 12'h900, 0, 0, 0, "R2");
        drive(1, 8'h40, 12'h7FF, 0, 0, 0, "R2");
        // R6: random stream with gaps and occasional writes
        for (int n = 0; n < 400; n++) begin
            bit v;
            bit we;
            v  = ($urandom() % 4) != 0;
            we = ($urandom() % 8) == 0;
            drive(v, 8'($urandom()), 12'($urandom()), we, int'($urandom() % 8),
                  int'($urandom() % 20480), v ? "R6" : "R7");
        end
        repeat (3) drive(0, 8'hFF, 12'h123, 0, 0, 0, "R7");
        report();
    end
endmodule